// File: doc/BRIEF.md
# Table-Driven Mixed-Radix DFT Schedule Sequencer

This control block converts a requested transform size into the per-cycle loop schedule for a mixed-radix DFT array. The array is one row of six lanes. Each transform of N = N3 × N4 points is split into a column phase and a row phase. The column phase runs N4 blocks, each an N3-point DFT. The row phase runs N3 blocks, each an N4-point DFT. Every block is factored as r1 × r2 with both factors at most six. The left lanes run the r1-point step and the right lanes run the r2-point step. When r2 is 1, the right side is idle.

Nothing about a size is hard-coded in the control logic. A parameter record per size index holds the factor pair and block count of each phase, plus the twiddle use of each phase. The record is read from a registered ROM and loaded into the loop-bound registers before the first issue. Adding a size therefore means adding a table row. Power-of-two sizes use the same record format as the sizes with factors of 3 and 5.

The sequencer accepts a request only while it is idle. It then issues one control word per cycle until the last row block has been issued, and then pulses done.

Top module: `mrdft_sequencer`

## Requirements
- R1: After reset, busy, done, err and issue are all 0.
- R2: A start seen while idle with a programmed index (size_sel < 6) raises busy on the next edge. The first issue appears one edge after that. err is cleared to 0 on acceptance.
- R3: A start seen while idle with an unprogrammed index (size_sel ≥ 6) leaves busy at 0 and sets err to 1. err keeps that value until the next start seen while idle.
- R4: A start seen while busy is ignored: the running schedule, its record and err are unchanged.
- R5: The column phase has phase = 0 and runs blk_idx from 0 to N4−1 as the outer loop and sub_idx from 0 to c_r2−1 as the inner loop. It lasts N4·c_r2 issue cycles.
- R6: The row phase (phase = 1) follows the last column issue with no gap. It runs blk_idx from 0 to N3−1 outside and sub_idx from 0 to r_r2−1 inside.
- R7: During an issue, lmask has its low r1 bits set. rmask has its low r2 bits set when r2 > 1 and is 0 when r2 = 1. Both masks are 0 when issue is 0. Bit i of a mask is lane i.
- R8: rad_l and rad_r carry the current phase's r1 and r2 as unsigned values and are 0 when issue is 0. tw_en is 1 throughout the column phase. In the row phase, tw_en equals the record's row-twiddle bit.
- R9: done is high for exactly one cycle: the cycle right after the last row issue. In that cycle busy and issue are 0, and a new start is accepted.
- R10: The table is indexed as follows (N: column r1×r2 with N4 blocks / row r1×r2 with N3 blocks / row twiddle).
  - 0 → 12: 6×1 with 2 blocks / 2×1 with 6 blocks / 0
  - 1 → 24: 6×1 with 4 / 4×1 with 6 / 0
  - 2 → 36: 6×1 with 6 / 6×1 with 6 / 0
  - 3 → 64: 4×4 with 4 / 4×1 with 16 / 0
  - 4 → 540: 6×6 with 15 / 5×3 with 36 / 1
  - 5 → 1296: 6×6 with 36 / 6×6 with 36 / 1

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Size request strobe |
| size_sel | input | 6 | Requested size index |
| busy | output | 1 | Schedule load or walk in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last idle request named an unprogrammed index |
| issue | output | 1 | A control word is valid this cycle |
| phase | output | 1 | 0 = column phase, 1 = row phase |
| blk_idx | output | 6 | Block index within the phase |
| sub_idx | output | 3 | Step index within the block |
| lmask | output | 6 | Left-side active lanes |
| rmask | output | 6 | Right-side active lanes |
| rad_l | output | 3 | Left-side radix |
| rad_r | output | 3 | Right-side radix |
| tw_en | output | 1 | Twiddle multiply enable |

## Verification
Let E0 be the edge that samples start. busy is due one edge after E0. err is due in the same cycle as busy. The first control word is due two edges after E0, because the ROM read register and the loop-bound load each add a cycle. The words that follow come one per edge, and done is due one edge after the last row word. The bench drives inputs on the falling edge and samples on the next falling edge. It walks its expected nested loops in lockstep with the design, one comparison set per cycle, so a lost, extra or shifted cycle shows up as a mismatch at the exact cycle where it occurs. Ignored requests are checked by injecting a start in the middle of a walk and confirming that the following control words and err are unchanged.

// File: rtl/mrdft_pkg.sv
package mrdft_pkg;

    localparam int LANES     = 6;
    localparam int RAD_W     = $clog2(LANES + 1);
    localparam int BLK_W     = 6;
    localparam int SEL_W     = 6;
    localparam int NUM_SIZES = 6;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_COL  = 2'd2,
        S_ROW  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [RAD_W-1:0] c_r1;
        logic [RAD_W-1:0] c_r2;
        logic [BLK_W-1:0] c_blk;
        logic [RAD_W-1:0] r_r1;
        logic [RAD_W-1:0] r_r2;
        logic [BLK_W-1:0] r_blk;
        logic             c_tw;
        logic             r_tw;
    } plan_rec_t;

    function automatic plan_rec_t mk_rec(input int cr1, input int cr2, input int cb,
                                         input int rr1, input int rr2, input int rb,
                                         input int ctw, input int rtw);
        plan_rec_t r;
        r.c_r1  = RAD_W'(cr1);
        r.c_r2  = RAD_W'(cr2);
        r.c_blk = BLK_W'(cb);
        r.r_r1  = RAD_W'(rr1);
        r.r_r2  = RAD_W'(rr2);
        r.r_blk = BLK_W'(rb);
        r.c_tw  = (ctw != 0);
        r.r_tw  = (rtw != 0);
        return r;
    endfunction

    function automatic logic sel_valid(input logic [SEL_W-1:0] sel);
        return sel < SEL_W'(NUM_SIZES);
    endfunction

    // Size table: column factors/blocks, row factors/blocks, twiddle use
    function automatic plan_rec_t plan_lookup(input logic [SEL_W-1:0] sel);
        plan_rec_t r;
        case (sel)
            SEL_W'(0): r = mk_rec(6, 1,  2, 2, 1,  6, 1, 0); // 12
            SEL_W'(1): r = mk_rec(6, 1,  4, 4, 1,  6, 1, 0); // 24
            SEL_W'(2): r = mk_rec(6, 1,  6, 6, 1,  6, 1, 0); // 36
            SEL_W'(3): r = mk_rec(4, 4,  4, 4, 1, 16, 1, 0); // 64
            SEL_W'(4): r = mk_rec(6, 6, 15, 5, 3, 36, 1, 1); // 540
            SEL_W'(5): r = mk_rec(6, 6, 36, 6, 6, 36, 1, 1); // 1296
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrdft_rom.sv
module mrdft_rom
    import mrdft_pkg::*;
(
    input  logic             clk,
    input  logic             rd_en,
    input  logic [SEL_W-1:0] sel,
    output plan_rec_t        q
);

    always_ff @(posedge clk) begin
        if (rd_en) begin
            q <= plan_lookup(sel);
        end
    end

endmodule

// File: rtl/mrdft_loop_ctr.sv
module mrdft_loop_ctr #(
    parameter int IW = 3,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [IW-1:0] in_lim,
    input  logic [OW-1:0] out_lim,
    output logic [IW-1:0] in_q,
    output logic [OW-1:0] out_q,
    output logic          wrap
);

    logic [IW-1:0] in_nx;
    logic [OW-1:0] out_nx;
    logic          in_last;
    logic          out_last;

    assign in_nx    = in_q + IW'(1);
    assign out_nx   = out_q + OW'(1);
    assign in_last  = (in_nx == in_lim);
    assign out_last = (out_nx == out_lim);
    assign wrap     = step && in_last && out_last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (step) begin
            if (in_last) begin
                in_q  <= '0;
                out_q <= out_last ? '0 : out_nx;
            end else begin
                in_q <= in_nx;
            end
        end
    end

    p_inner_bound_r5: assert property (@(posedge clk) disable iff (rst)
        step |-> (in_q < in_lim));

    p_outer_bound_r5: assert property (@(posedge clk) disable iff (rst)
        step |-> (out_q < out_lim));

endmodule

// File: rtl/mrdft_lane_dec.sv
module mrdft_lane_dec #(
    parameter int LN = 6,
    parameter int RW = 3
) (
    input  logic          en,
    input  logic [RW-1:0] rad,
    output logic [LN-1:0] mask
);

    for (genvar i = 0; i < LN; i++) begin : g_lane
        assign mask[i] = en && (rad > RW'(i));
    end

    always_comb begin
        if (en) begin
            p_mask_count_r7: assert ($countones(mask) == int'(rad));
        end
    end

endmodule

// File: rtl/mrdft_sequencer.sv
module mrdft_sequencer
    import mrdft_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] size_sel,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             issue,
    output logic             phase,
    output logic [BLK_W-1:0] blk_idx,
    output logic [RAD_W-1:0] sub_idx,
    output logic [LANES-1:0] lmask,
    output logic [LANES-1:0] rmask,
    output logic [RAD_W-1:0] rad_l,
    output logic [RAD_W-1:0] rad_r,
    output logic             tw_en
);

    seq_state_e       state;
    plan_rec_t        rom_q;
    plan_rec_t        rec;
    logic             sel_ok;
    logic             accept;
    logic             run;
    logic             row_ph;
    logic             wrap;
    logic [RAD_W-1:0] cur_r1;
    logic [RAD_W-1:0] cur_r2;
    logic [BLK_W-1:0] cur_blk;
    logic [RAD_W-1:0] r2_lanes;

    assign sel_ok  = sel_valid(size_sel);
    assign accept  = (state == S_IDLE) && start && sel_ok;
    assign run     = (state == S_COL) || (state == S_ROW);
    assign row_ph  = (state == S_ROW);
    assign cur_r1  = row_ph ? rec.r_r1  : rec.c_r1;
    assign cur_r2  = row_ph ? rec.r_r2  : rec.c_r2;
    assign cur_blk = row_ph ? rec.r_blk : rec.c_blk;
    assign r2_lanes = (cur_r2 > RAD_W'(1)) ? cur_r2 : '0;

    mrdft_rom u_rom (
        .clk   (clk),
        .rd_en (accept),
        .sel   (size_sel),
        .q     (rom_q)
    );

    mrdft_loop_ctr #(.IW(RAD_W), .OW(BLK_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr     (state == S_LOAD),
        .step    (run),
        .in_lim  (cur_r2),
        .out_lim (cur_blk),
        .in_q    (sub_idx),
        .out_q   (blk_idx),
        .wrap    (wrap)
    );

    mrdft_lane_dec #(.LN(LANES), .RW(RAD_W)) u_left (
        .en   (run),
        .rad  (cur_r1),
        .mask (lmask)
    );

    mrdft_lane_dec #(.LN(LANES), .RW(RAD_W)) u_right (
        .en   (run),
        .rad  (r2_lanes),
        .mask (rmask)
    );

    assign busy  = (state != S_IDLE);
    assign issue = run;
    assign phase = row_ph;
    assign rad_l = run ? cur_r1 : '0;
    assign rad_r = run ? cur_r2 : '0;
    assign tw_en = run && (row_ph ? rec.r_tw : rec.c_tw);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            rec   <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        err <= !sel_ok;
                        if (sel_ok) state <= S_LOAD;
                    end
                end
                S_LOAD: begin
                    rec   <= rom_q;
                    state <= S_COL;
                end
                S_COL: begin
                    if (wrap) state <= S_ROW;
                end
                S_ROW: begin
                    if (wrap) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    p_err_nostart_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !sel_ok) |=> (!busy && err));

    p_rec_hold_r4: assert property (@(posedge clk) disable iff (rst)
        run |=> $stable(rec));

    p_phase_order_r6: assert property (@(posedge clk) disable iff (rst)
        (issue && phase) |=> (!issue || phase));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !issue));

endmodule

// File: tb/mrdft_sequencer_test.sv
module mrdft_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] size_sel = '0;
    logic       busy, done, err, issue, phase, tw_en;
    logic [5:0] blk_idx, lmask, rmask;
    logic [2:0] sub_idx, rad_l, rad_r;

    int checks = 0;
    int errors = 0;

    // idx, col r1, col r2, col blocks, row r1, row r2, row blocks, col tw, row tw
    localparam int PLAN [6][9] = '{
        '{0, 6, 1,  2, 2, 1,  6, 1, 0},
        '{1, 6, 1,  4, 4, 1,  6, 1, 0},
        '{2, 6, 1,  6, 6, 1,  6, 1, 0},
        '{3, 4, 4,  4, 4, 1, 16, 1, 0},
        '{4, 6, 6, 15, 5, 3, 36, 1, 1},
        '{5, 6, 6, 36, 6, 6, 36, 1, 1}
    };

    always #4 clk = ~clk;

    mrdft_sequencer uut (
        .clk(clk), .rst(rst), .start(start), .size_sel(size_sel),
        .busy(busy), .done(done), .err(err), .issue(issue), .phase(phase),
        .blk_idx(blk_idx), .sub_idx(sub_idx), .lmask(lmask), .rmask(rmask),
        .rad_l(rad_l), .rad_r(rad_r), .tw_en(tw_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_plan(input int v, input bit poke);
        @(negedge clk);
        start = 1'b1;
        size_sel = 6'(PLAN[v][0]);
        @(negedge clk);
        start = 1'b0;
        chk("R2", "busy after accept", int'(busy), 1);
        chk("R2", "no issue in load", int'(issue), 0);
        chk("R2", "err cleared", int'(err), 0);
        for (int ph = 0; ph < 2; ph++) begin
            int r1 = (ph == 0) ? PLAN[v][1] : PLAN[v][4];
            int r2 = (ph == 0) ? PLAN[v][2] : PLAN[v][5];
            int nb = (ph == 0) ? PLAN[v][3] : PLAN[v][6];
            int tw = (ph == 0) ? PLAN[v][7] : PLAN[v][8];
            for (int b = 0; b < nb; b++) begin
                for (int s = 0; s < r2; s++) begin
                    @(negedge clk);
                    start = 1'b0;
                    chk(ph == 0 ? "R5" : "R6", "issue", int'(issue), 1);
                    chk(ph == 0 ? "R5" : "R6", "phase", int'(phase), ph);
                    chk(ph == 0 ? "R5" : "R6", "blk_idx", int'(blk_idx), b);
                    chk(ph == 0 ? "R5" : "R6", "sub_idx", int'(sub_idx), s);
                    chk("R7", "lmask", int'(lmask), (1 << r1) - 1);
                    chk("R7", "rmask", int'(rmask), (r2 > 1) ? ((1 << r2) - 1) : 0);
                    chk("R8", "rad_l", int'(rad_l), r1);
                    chk("R8", "rad_r", int'(rad_r), r2);
                    chk("R8", "tw_en", int'(tw_en), tw);
                    chk("R4", "err steady", int'(err), 0);
                    if (poke && ph == 0 && b == 2 && s == 0) begin
                        start = 1'b1;
                        size_sel = 6'd0;
                    end
                end
            end
        end
        @(negedge clk);
        chk("R9", "done pulse", int'(done), 1);
        chk("R9", "busy low at done", int'(busy), 0);
        chk("R9", "issue low at done", int'(issue), 0);
        @(negedge clk);
        chk("R9", "done single cycle", int'(done), 0);
        chk("R7", "lmask idle", int'(lmask), 0);
        chk("R8", "rad_l idle", int'(rad_l), 0);
    endtask

    task automatic bad_request(input int sel);
        @(negedge clk);
        start = 1'b1;
        size_sel = 6'(sel);
        @(negedge clk);
        start = 1'b0;
        chk("R3", "busy stays low", int'(busy), 0);
        chk("R3", "err set", int'(err), 1);
        @(negedge clk);
        chk("R3", "no issue", int'(issue), 0);
        chk("R3", "err held", int'(err), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "busy reset", int'(busy), 0);
        chk("R1", "done reset", int'(done), 0);
        chk("R1", "err reset", int'(err), 0);
        chk("R1", "issue reset", int'(issue), 0);

        // R10: every table row walked in full
        for (int v = 0; v < 6; v++) begin
            run_plan(v, 1'b0);
        end

        // R4: request injected mid-walk is ignored
        run_plan(4, 1'b1);

        // R3: unprogrammed indices, then recovery by a valid request
        bad_request(6);
        bad_request(63);
        run_plan(3, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule